// File: doc/BRIEF.md
# GPIO Edge-Detect Interrupt Unit

This block watches a bank of general-purpose input pins, brings each one into the local clock domain, and records rising and falling transitions in a sticky status register. Software uses a small register port to choose, pin by pin, which transitions are recorded. It can also choose which recorded transitions may wake the system, and it clears recorded events by writing ones to the status register.

The low group of pins, 0 to 10, each get a dedicated interrupt request that follows that pin's status bit. The remaining pins, 11 to 27, are merged into one shared request, so a handler has to read the status register to find the source. A separate wake request is raised while any recorded event belongs to a pin whose wake enable is set. The interrupt controller, pin direction and output drive are outside this block.

Top module: `gpio_edge_irq_unit`

## Requirements
- R1: After a synchronous reset, the rising-enable, falling-enable, wake-enable and status registers all read zero, and every request output is low.
- R2: The rising-enable register sits at address 0. With a pin's bit set there, a 0-to-1 transition on that pin sets status bit i. A 1-to-0 transition sets nothing unless falling is also enabled.
- R3: The falling-enable register sits at address 1. With a pin's bit set there, a 1-to-0 transition sets status bit i. A 0-to-1 transition sets nothing unless rising is also enabled.
- R4: With both enable bits set for a pin, either transition direction sets its status bit.
- R5: The status register sits at address 3. Writing it clears every bit written as 1 and leaves every bit written as 0 unchanged. A status bit never clears in any other way.
- R6: Writing all ones to the status register clears every pending event in one write.
- R7: Output irq_direct_o[i], for i from 0 to 10, equals status bit i.
- R8: Output irq_shared_o is high exactly when at least one of status bits 11 to 27 is set.
- R9: The wake-enable register sits at address 2. Output wake_req_o is high exactly when some status bit is set whose wake-enable bit is also set.
- R10: A pin with both enable bits clear records no new events, and the status bits it already holds are kept.
- R11: If a transition is recorded in the same cycle that software writes 1 to that status bit, the bit stays set.
- R12: A pin change applied before clock edge n is visible in the status register after edge n+2. This delay comes from a two-flop synchroniser followed by one compare stage.
- R13: reg_rdata_o returns, without delay, the register selected by reg_addr_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pins_i | input | 28 | Asynchronous pin levels |
| reg_addr_i | input | 2 | Register select: 0 rising enable, 1 falling enable, 2 wake enable, 3 status |
| reg_wen_i | input | 1 | Write strobe, sampled on the rising clock edge |
| reg_wdata_i | input | 28 | Write data |
| reg_rdata_o | output | 28 | Combinational read of the selected register |
| irq_direct_o | output | 11 | Dedicated requests for pins 0 to 10 |
| irq_shared_o | output | 1 | Merged request for pins 11 to 27 |
| wake_req_o | output | 1 | Wake request |

## Verification
A pin change is first seen in status, and in the three request outputs that derive from it, after the third rising edge following the change. A register write becomes visible one edge after the strobe is sampled. Read data follows the address with no delay. The bench drives inputs on the falling edge. A behavioural model keeps a three-deep history of sampled pin values and applies the same edge counts, and every output is compared against that model one time unit after each falling edge. The directed checks sample status before and after the exact edge at which the event should land, including the edge at which a clear collides with a new event.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;

    localparam int unsigned NUM_PINS    = 28;
    localparam int unsigned NUM_DIRECT  = 11;
    localparam int unsigned SYNC_STAGES = 2;
    localparam int unsigned ADDR_W      = 2;

    typedef enum logic [ADDR_W-1:0] {
        SEL_RISE_EN = 2'd0,
        SEL_FALL_EN = 2'd1,
        SEL_WAKE_EN = 2'd2,
        SEL_STATUS  = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic     wen;
        reg_sel_e sel;
    } reg_cmd_t;

    // Sticky status update: new events win over a simultaneous clear.
    function automatic logic [NUM_PINS-1:0] sticky_next(
        input logic [NUM_PINS-1:0] cur,
        input logic [NUM_PINS-1:0] clr,
        input logic [NUM_PINS-1:0] set
    );
        return (cur & ~clr) | set;
    endfunction

endpackage

// File: rtl/gpio_edge_sync.sv
module gpio_edge_sync
    import gpio_edge_pkg::*;
#(
    parameter int unsigned N      = NUM_PINS,
    parameter int unsigned STAGES = SYNC_STAGES
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] pins_i,
    output logic [N-1:0] rise_o,
    output logic [N-1:0] fall_o
);

    for (genvar i = 0; i < N; i++) begin : g_pin
        logic [STAGES-1:0] chain_q;
        logic              last_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                chain_q <= '0;
                last_q  <= 1'b0;
            end else begin
                chain_q <= {chain_q[STAGES-2:0], pins_i[i]};
                last_q  <= chain_q[STAGES-1];
            end
        end

        assign rise_o[i] =  chain_q[STAGES-1] & ~last_q;
        assign fall_o[i] = ~chain_q[STAGES-1] &  last_q;
    end

endmodule

// File: rtl/gpio_edge_regs.sv
module gpio_edge_regs
    import gpio_edge_pkg::*;
#(
    parameter int unsigned N = NUM_PINS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wen_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [N-1:0]      wdata_i,
    input  logic [N-1:0]      rise_evt_i,
    input  logic [N-1:0]      fall_evt_i,
    output logic [N-1:0]      rise_en_o,
    output logic [N-1:0]      fall_en_o,
    output logic [N-1:0]      wake_en_o,
    output logic [N-1:0]      status_o,
    output logic [N-1:0]      set_o,
    output logic [N-1:0]      clr_o,
    output logic [N-1:0]      rdata_o
);

    reg_cmd_t     cmd;
    logic [N-1:0] rise_en_q, fall_en_q, wake_en_q, status_q;

    assign cmd.wen = wen_i;
    assign cmd.sel = reg_sel_e'(addr_i);

    assign set_o = (rise_evt_i & rise_en_q) | (fall_evt_i & fall_en_q);
    assign clr_o = (cmd.wen && cmd.sel == SEL_STATUS) ? wdata_i : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            rise_en_q <= '0;
            fall_en_q <= '0;
            wake_en_q <= '0;
        end else if (cmd.wen) begin
            case (cmd.sel)
                SEL_RISE_EN: rise_en_q <= wdata_i;
                SEL_FALL_EN: fall_en_q <= wdata_i;
                SEL_WAKE_EN: wake_en_q <= wdata_i;
                default:     ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) status_q <= '0;
        else     status_q <= sticky_next(status_q, clr_o, set_o);
    end

    always_comb begin
        case (cmd.sel)
            SEL_RISE_EN: rdata_o = rise_en_q;
            SEL_FALL_EN: rdata_o = fall_en_q;
            SEL_WAKE_EN: rdata_o = wake_en_q;
            default:     rdata_o = status_q;
        endcase
    end

    assign rise_en_o = rise_en_q;
    assign fall_en_o = fall_en_q;
    assign wake_en_o = wake_en_q;
    assign status_o  = status_q;

endmodule

// File: rtl/gpio_edge_req.sv
module gpio_edge_req
    import gpio_edge_pkg::*;
#(
    parameter int unsigned N  = NUM_PINS,
    parameter int unsigned ND = NUM_DIRECT
) (
    input  logic [N-1:0]  status_i,
    input  logic [N-1:0]  wake_en_i,
    output logic [ND-1:0] irq_direct_o,
    output logic          irq_shared_o,
    output logic          wake_req_o
);

    assign irq_direct_o = status_i[ND-1:0];
    assign irq_shared_o = |status_i[N-1:ND];
    assign wake_req_o   = |(status_i & wake_en_i);

endmodule

// File: rtl/gpio_edge_irq_unit.sv
module gpio_edge_irq_unit
    import gpio_edge_pkg::*;
#(
    parameter int unsigned N  = NUM_PINS,
    parameter int unsigned ND = NUM_DIRECT
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N-1:0]      pins_i,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic              reg_wen_i,
    input  logic [N-1:0]      reg_wdata_i,
    output logic [N-1:0]      reg_rdata_o,
    output logic [ND-1:0]     irq_direct_o,
    output logic              irq_shared_o,
    output logic              wake_req_o
);

    logic [N-1:0] rise_evt, fall_evt;
    logic [N-1:0] rise_en_q, fall_en_q, wake_en_q, status_q;
    logic [N-1:0] set_vec, clr_vec;

    gpio_edge_sync #(.N(N), .STAGES(SYNC_STAGES)) sync_i (
        .clk    (clk),
        .rst    (rst),
        .pins_i (pins_i),
        .rise_o (rise_evt),
        .fall_o (fall_evt)
    );

    gpio_edge_regs #(.N(N)) regs_i (
        .clk        (clk),
        .rst        (rst),
        .wen_i      (reg_wen_i),
        .addr_i     (reg_addr_i),
        .wdata_i    (reg_wdata_i),
        .rise_evt_i (rise_evt),
        .fall_evt_i (fall_evt),
        .rise_en_o  (rise_en_q),
        .fall_en_o  (fall_en_q),
        .wake_en_o  (wake_en_q),
        .status_o   (status_q),
        .set_o      (set_vec),
        .clr_o      (clr_vec),
        .rdata_o    (reg_rdata_o)
    );

    gpio_edge_req #(.N(N), .ND(ND)) req_i (
        .status_i     (status_q),
        .wake_en_i    (wake_en_q),
        .irq_direct_o (irq_direct_o),
        .irq_shared_o (irq_shared_o),
        .wake_req_o   (wake_req_o)
    );

endmodule

// File: rtl/gpio_edge_irq_unit_chk.sv
module gpio_edge_irq_unit_chk #(
    parameter int unsigned N  = 28,
    parameter int unsigned ND = 11
) (
    input logic          clk,
    input logic          rst,
    input logic [N-1:0]  status,
    input logic [N-1:0]  rise_en,
    input logic [N-1:0]  fall_en,
    input logic [N-1:0]  wake_en,
    input logic [N-1:0]  set_vec,
    input logic [N-1:0]  clr_vec,
    input logic [ND-1:0] irq_direct,
    input logic          irq_shared,
    input logic          wake_req
);

    AST_RESET_CLEAN: assert property (@(posedge clk) rst |=> (status == '0)); // R1

    AST_NO_SET_WHEN_DISABLED: assert property (@(posedge clk) disable iff (rst)
        ((status & ~$past(status) & ~$past(rise_en | fall_en)) == '0)); // R10

    AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (rst)
        (($past(status) & ~$past(clr_vec) & ~status) == '0)); // R5

    AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (rst)
        ((status & $past(clr_vec) & ~$past(set_vec)) == '0)); // R5

    AST_EVENT_BEATS_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (($past(set_vec) & ~status) == '0)); // R11

    AST_DIRECT_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        (irq_direct == status[ND-1:0])); // R7

    AST_SHARED_MERGE: assert property (@(posedge clk) disable iff (rst)
        (irq_shared == (|status[N-1:ND]))); // R8

    AST_WAKE_GATED: assert property (@(posedge clk) disable iff (rst)
        (wake_req == (|(status & wake_en)))); // R9

endmodule

bind gpio_edge_irq_unit gpio_edge_irq_unit_chk #(.N(N), .ND(ND)) chk_i (
    .clk        (clk),
    .rst        (rst),
    .status     (status_q),
    .rise_en    (rise_en_q),
    .fall_en    (fall_en_q),
    .wake_en    (wake_en_q),
    .set_vec    (set_vec),
    .clr_vec    (clr_vec),
    .irq_direct (irq_direct_o),
    .irq_shared (irq_shared_o),
    .wake_req   (wake_req_o)
);

// File: tb/gpio_edge_irq_unit_tb_top.sv
`timescale 1ns/1ps
module gpio_edge_irq_unit_tb_top;

    localparam int N  = 28;
    localparam int ND = 11;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [N-1:0]  pins = '0;
    logic [1:0]    raddr = 2'd3;
    logic          wen = 1'b0;
    logic [N-1:0]  wdata = '0;
    logic [N-1:0]  rdata;
    logic [ND-1:0] irq_direct;
    logic          irq_shared;
    logic          wake_req;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    gpio_edge_irq_unit dut_i (
        .clk          (clk),
        .rst          (rst),
        .pins_i       (pins),
        .reg_addr_i   (raddr),
        .reg_wen_i    (wen),
        .reg_wdata_i  (wdata),
        .reg_rdata_o  (rdata),
        .irq_direct_o (irq_direct),
        .irq_shared_o (irq_shared),
        .wake_req_o   (wake_req)
    );

    // Behavioural reference: history of sampled pin levels, register images.
    logic [N-1:0] m_rise, m_fall, m_wake, m_stat;
    logic [N-1:0] h1, h2, h3;

    always @(posedge clk) begin
        logic [N-1:0] up, dn, clr;
        if (rst) begin
            m_rise = '0; m_fall = '0; m_wake = '0; m_stat = '0;
            h1 = '0; h2 = '0; h3 = '0;
        end else begin
            up  = h2 & ~h3;
            dn  = ~h2 & h3;
            clr = (wen && raddr == 2'd3) ? wdata : '0;
            m_stat = (m_stat & ~clr) | (up & m_rise) | (dn & m_fall);
            if (wen && raddr == 2'd0) m_rise = wdata;
            if (wen && raddr == 2'd1) m_fall = wdata;
            if (wen && raddr == 2'd2) m_wake = wdata;
            h3 = h2; h2 = h1; h1 = pins;
        end
    end

    task automatic check(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [N-1:0] model_read(input logic [1:0] a);
        case (a)
            2'd0: return m_rise;
            2'd1: return m_fall;
            2'd2: return m_wake;
            default: return m_stat;
        endcase
    endfunction

    // Per-cycle comparison against the model.
    always @(negedge clk) begin
        #1;
        if (!rst && !done) begin
            check("R7 direct",  N'(irq_direct), N'(m_stat[ND-1:0]));
            check("R8 shared",  N'(irq_shared), N'(|m_stat[N-1:ND]));
            check("R9 wake",    N'(wake_req),   N'(|(m_stat & m_wake)));
            check("R13 rdata",  rdata,          model_read(raddr));
        end
    end

    task automatic wr(input logic [1:0] a, input logic [N-1:0] d);
        @(negedge clk);
        raddr = a; wen = 1'b1; wdata = d;
        @(negedge clk);
        wen = 1'b0; raddr = 2'd3; wdata = '0;
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
        #2;
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 50000 && !done) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected<=50000", cycles);
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state of every register and output
        for (int a = 0; a < 4; a++) begin
            raddr = 2'(a);
            #1 check("R1 reg", rdata, '0);
        end
        raddr = 2'd3;
        check("R1 irq", N'({irq_direct, irq_shared, wake_req}), '0);

        // R12 / R2: rising enable on pins 0, 5, 20; pin 5 rises
        wr(2'd0, N'(28'h0100021));
        @(negedge clk); pins[5] = 1'b1;
        @(negedge clk); #1 check("R12 after edge n", rdata, '0);
        @(negedge clk); #1 check("R12 after edge n+1", rdata, '0);
        @(negedge clk); #1 check("R12 after edge n+2", rdata, N'(28'h20));
        check("R7 pin5 line", N'(irq_direct), N'(11'h020));
        @(negedge clk); pins[5] = 1'b0;
        settle(5);
        check("R2 falling ignored", rdata, N'(28'h20));

        // R3: falling enable on pins 1 and 12
        wr(2'd1, N'(28'h0001002));
        @(negedge clk); pins[1] = 1'b1; pins[12] = 1'b1;
        settle(5);
        check("R3 rising ignored", rdata, N'(28'h20));
        @(negedge clk); pins[1] = 1'b0; pins[12] = 1'b0;
        settle(5);
        check("R3 falling seen", rdata, N'(28'h1022));
        check("R8 shared high", N'(irq_shared), N'(1));

        // R5: write-one-to-clear, zeros leave bits alone
        wr(2'd3, N'(28'h0000002));
        settle(1);
        check("R5 clear one bit", rdata, N'(28'h1020));
        wr(2'd3, '0);
        settle(1);
        check("R5 zero write", rdata, N'(28'h1020));

        // R9: wake enable selects sources
        wr(2'd2, N'(28'h0001000));
        settle(1);
        check("R9 wake on pin12", N'(wake_req), N'(1));
        wr(2'd2, N'(28'h0000080));
        settle(1);
        check("R9 wake masked", N'(wake_req), N'(0));

        // R4: both edges on pin 7
        wr(2'd0, N'(28'h01000A1));
        wr(2'd1, N'(28'h0001082));
        @(negedge clk); pins[7] = 1'b1;
        settle(5);
        check("R4 rise on both", rdata, N'(28'h10A0));
        check("R9 wake on pin7", N'(wake_req), N'(1));
        wr(2'd3, N'(28'h80));
        @(negedge clk); pins[7] = 1'b0;
        settle(5);
        check("R4 fall on both", rdata, N'(28'h10A0));

        // R11: clear collides with a new event on pin 7
        wr(2'd3, N'(28'h80));
        settle(1);
        check("R11 pre-clear", rdata, N'(28'h1020));
        @(negedge clk); pins[7] = 1'b1;
        @(negedge clk);
        @(negedge clk); raddr = 2'd3; wen = 1'b1; wdata = N'(28'h80);
        @(negedge clk); wen = 1'b0; wdata = '0;
        #1 check("R11 event kept", rdata, N'(28'h10A0));

        // R10: disable both edges, status kept, no new events
        wr(2'd0, '0);
        wr(2'd1, '0);
        for (int k = 0; k < 6; k++) begin
            @(negedge clk); pins = ~pins;
            settle(1);
        end
        settle(4);
        check("R10 status kept", rdata, N'(28'h10A0));

        // R6: all ones clears everything
        wr(2'd3, {N{1'b1}});
        settle(1);
        check("R6 all cleared", rdata, '0);
        check("R6 lines low", N'({irq_direct, irq_shared, wake_req}), '0);

        // Mixed traffic, compared every cycle against the model
        for (int k = 0; k < 400; k++) begin
            @(negedge clk);
            pins = N'($urandom);
            wen  = ($urandom_range(0, 3) == 0);
            raddr = 2'($urandom_range(0, 3));
            wdata = N'($urandom);
        end
        @(negedge clk); wen = 1'b0; raddr = 2'd3;
        settle(4);
        finish_run();
    end

endmodule